// File: doc/BRIEF.md
# Interlocked Serial Port Control Register

This block is one 16-bit control register on a codec's register bus. It holds a master enable for serial data output, an enable for a second serial data output, an enable for the serial bit clock, and a two-bit field that selects the data format. The three enables are interlocked with status flags kept in other registers: a power-ready flag, a digital-audio-output enable and an external-amplifier-powerdown flag. These flags arrive here as plain inputs.

The interlocks act in two ways. An enable that is written while its conditions are not met is refused. An enable that is stored but whose conditions no longer hold reads back as zero and is held low at its output pin. When the master enable drops, the two dependent enables clear themselves, so they stay low when the master is turned on again.

The master enable is held by a two-state machine. The states are `ST_OFF` and `ST_ON`. The transitions are:
- **arm** (`ST_OFF` to `ST_ON`): a write with bit 15 set while power-ready is 1.
- **disarm** (`ST_ON` to `ST_OFF`): a write with bit 15 clear.
- **power loss** (`ST_ON` to `ST_OFF`): power-ready is 0 at a clock edge.

Each dependent enable takes the next state of the machine into account. A single write can therefore set the master and its dependents together.

Top module: `spctl_top`

## Requirements
- R1: Writes change the register only when `addr` equals 6Ah. `rd_data` shows the register when `addr` equals 6Ah and reads 0000h for any other address.
- R2: After reset the register reads 0000h and every control output is 0.
- R3: Bit 15, the master enable, is set by a write only while `pwr_ready` is 1. It reads 0 whenever `pwr_ready` is 0.
- R4: If `pwr_ready` is 0 at a clock edge, the stored master enable clears. It stays 0 after `pwr_ready` returns to 1 until it is written again.
- R5: Bit 3, the second-output enable, is accepted by a write only if the master enable after that write is 1 and `dig_out_en` is 0. It reads 0 whenever the master enable reads 0 or `dig_out_en` is 1.
- R6: Bit 2, the serial clock enable, is accepted by a write only if the master enable after that write is 1 and `amp_pdn` is 0. It reads 0 whenever the master enable reads 0 or `amp_pdn` is 1.
- R7: When the stored master enable becomes 0, bits 3 and 2 clear. They remain 0 when the master is set again without writing them.
- R8: A single write of 800Ch, made with `pwr_ready`=1, `dig_out_en`=0 and `amp_pdn`=0, sets the master enable and both dependent enables in the same cycle.
- R9: Bits 1:0, the format select, take every write with no interlock. Bits 14 to 4 always read 0.
- R10: The outputs `ser_en`, `ser2_en`, `sclk_en` and `fmt` always equal bits 15, 3, 2 and 1:0 of the register read value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| addr | input | 7 | Register index for reads and writes |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data with interlocks applied |
| pwr_ready | input | 1 | Power-ready flag from another register |
| dig_out_en | input | 1 | Digital-audio-output enable from another register |
| amp_pdn | input | 1 | External amplifier powerdown flag from another register |
| ser_en | output | 1 | Qualified master serial data enable |
| ser2_en | output | 1 | Qualified second-output enable |
| sclk_en | output | 1 | Qualified serial clock enable |
| fmt | output | 2 | Format select (00 I2S, 01 left-justified, 10 right-justified 20-bit, 11 right-justified 16-bit) |

## Verification
A write to the dependent bits can land in the same cycle as a change of the master enable. That change is either the master being set by the same write or the master being lost because `pwr_ready` drops.

Both cases are provoked on purpose: a combined 800Ch write, and writes of bits 3 and 2 made while `pwr_ready` is low. Constrained-random cycles also mix writes, flag toggles and power loss. Each cycle is judged against a bench model that applies the master's next value before the dependent bits are accepted, and it compares both the gated read value and the output pins.

// File: rtl/spctl_pkg.sv
package spctl_pkg;
    localparam int REG_W     = 16;
    localparam int BIT_MSTR  = 15;
    localparam int BIT_SER2  = 3;
    localparam int BIT_SCLK  = 2;
    localparam int N_DEP     = 2;   // dependent enables: [0] second output, [1] serial clock

    typedef enum logic {
        ST_OFF = 1'b0,
        ST_ON  = 1'b1
    } mstr_state_e;
endpackage

// File: rtl/spctl_master_fsm.sv
module spctl_master_fsm
    import spctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_hit,
    input  logic wr_mstr,
    input  logic pwr_ready,
    output logic mstr_nxt,
    output logic mstr_rd
);
    mstr_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // transitions: arm, disarm, power loss
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: if (pwr_ready && wr_hit && wr_mstr) state_d = ST_ON;
            ST_ON: begin
                if (!pwr_ready)                 state_d = ST_OFF;
                else if (wr_hit && !wr_mstr)    state_d = ST_OFF;
            end
            default: state_d = ST_OFF;
        endcase
    end

    // outputs
    always_comb begin
        mstr_nxt = (state_d == ST_ON);
        mstr_rd  = (state_q == ST_ON) && pwr_ready;
    end
endmodule

// File: rtl/spctl_dep_bit.sv
module spctl_dep_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_hit,
    input  logic wr_bit,
    input  logic mstr_nxt,
    input  logic mstr_rd,
    input  logic inhibit,
    output logic bit_rd
);
    logic bit_q, bit_d;

    always_comb begin
        if (!mstr_nxt)   bit_d = 1'b0;
        else if (wr_hit) bit_d = wr_bit && !inhibit;
        else             bit_d = bit_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bit_q <= 1'b0;
        else        bit_q <= bit_d;
    end

    assign bit_rd = bit_q && mstr_rd && !inhibit;
endmodule

// File: rtl/spctl_top.sv
module spctl_top
    import spctl_pkg::*;
#(
    parameter int              ADDR_W    = 7,
    parameter logic [ADDR_W-1:0] REG_INDEX = 7'h6A,
    parameter int              FMT_W     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    input  logic              pwr_ready,
    input  logic              dig_out_en,
    input  logic              amp_pdn,
    output logic              ser_en,
    output logic              ser2_en,
    output logic              sclk_en,
    output logic [FMT_W-1:0]  fmt
);
    localparam int PAD_W = BIT_SCLK - FMT_W;

    logic             wr_hit;
    logic             mstr_nxt, mstr_rd;
    logic [N_DEP-1:0] dep_wr, dep_inh, dep_rd;
    logic [FMT_W-1:0] fmt_q;
    logic [REG_W-1:0] reg_view;

    assign wr_hit  = wr_en && (addr == REG_INDEX);
    assign dep_wr  = {wr_data[BIT_SCLK], wr_data[BIT_SER2]};
    assign dep_inh = {amp_pdn, dig_out_en};

    spctl_master_fsm u_mstr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_hit   (wr_hit),
        .wr_mstr  (wr_data[BIT_MSTR]),
        .pwr_ready(pwr_ready),
        .mstr_nxt (mstr_nxt),
        .mstr_rd  (mstr_rd)
    );

    for (genvar g = 0; g < N_DEP; g++) begin : g_dep
        spctl_dep_bit u_dep (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_hit  (wr_hit),
            .wr_bit  (dep_wr[g]),
            .mstr_nxt(mstr_nxt),
            .mstr_rd (mstr_rd),
            .inhibit (dep_inh[g]),
            .bit_rd  (dep_rd[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      fmt_q <= '0;
        else if (wr_hit) fmt_q <= wr_data[FMT_W-1:0];
    end

    always_comb begin
        reg_view           = '0;
        reg_view[BIT_MSTR] = mstr_rd;
        reg_view[BIT_SER2] = dep_rd[0];
        reg_view[BIT_SCLK] = dep_rd[1];
        reg_view[FMT_W-1:0] = fmt_q;
    end

    always_comb begin
        rd_data = (addr == REG_INDEX) ? reg_view : '0;
        ser_en  = mstr_rd;
        ser2_en = dep_rd[0];
        sclk_en = dep_rd[1];
        fmt     = fmt_q;
    end

    if (PAD_W < 0) begin : g_bad_fmt
        initial $error("format field overlaps enable bits");
    end
endmodule

// File: rtl/spctl_chk.sv
module spctl_chk #(
    parameter int              ADDR_W    = 7,
    parameter logic [ADDR_W-1:0] REG_INDEX = 7'h6A,
    parameter int              FMT_W     = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [15:0]       wr_data,
    input logic [15:0]       rd_data,
    input logic              pwr_ready,
    input logic              dig_out_en,
    input logic              amp_pdn,
    input logic              ser_en,
    input logic              ser2_en,
    input logic              sclk_en,
    input logic [FMT_W-1:0]  fmt
);
    logic hit;
    assign hit = wr_en && (addr == REG_INDEX);

    a_r3_master_needs_power: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ready |-> !ser_en);
    a_r4_power_loss_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ready |=> !ser_en);
    a_r5_ser2_interlock: assert property (@(posedge clk) disable iff (!rst_n)
        ser2_en |-> (ser_en && !dig_out_en));
    a_r6_sclk_interlock: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_en |-> (ser_en && !amp_pdn));
    a_r7_cascade_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_en && !hit) |=> (!ser2_en && !sclk_en));
    a_r8_joint_write: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && pwr_ready && wr_data[15] && wr_data[3] && !dig_out_en)
        |=> (ser2_en || dig_out_en || !pwr_ready));
    a_r9_fmt_write: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (fmt == $past(wr_data[FMT_W-1:0])));
    a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[14:4] == 11'd0);
    a_r1_other_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr != REG_INDEX) |-> (rd_data == 16'h0000));
endmodule

bind spctl_top spctl_chk #(
    .ADDR_W(ADDR_W), .REG_INDEX(REG_INDEX), .FMT_W(FMT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .pwr_ready(pwr_ready), .dig_out_en(dig_out_en),
    .amp_pdn(amp_pdn), .ser_en(ser_en), .ser2_en(ser2_en), .sclk_en(sclk_en),
    .fmt(fmt)
);

// File: tb/tb_spctl_top.sv
module tb_spctl_top;
    localparam logic [6:0] IDX = 7'h6A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [6:0]  addr = IDX;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        pwr_ready = 1'b0, dig_out_en = 1'b0, amp_pdn = 1'b0;
    logic        ser_en, ser2_en, sclk_en;
    logic [1:0]  fmt;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // bench model state
    bit       m_q, s2_q, sc_q;
    bit [1:0] f_q;

    spctl_top dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .pwr_ready(pwr_ready), .dig_out_en(dig_out_en),
        .amp_pdn(amp_pdn), .ser_en(ser_en), .ser2_en(ser2_en), .sclk_en(sclk_en),
        .fmt(fmt)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog: actual cycles %0d expected below 20000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_view();
        bit mr, s2r, scr;
        mr  = m_q && pwr_ready;
        s2r = s2_q && mr && !dig_out_en;
        scr = sc_q && mr && !amp_pdn;
        return {mr, 11'd0, s2r, scr, f_q};
    endfunction

    // drive one cycle: check combinational view, then advance model and design
    task automatic step(input bit we, input logic [6:0] a, input logic [15:0] d,
                        input bit pr, input bit dg, input bit ap);
        logic [15:0] v;
        bit hit, mn;
        wr_en = we; addr = a; wr_data = d;
        pwr_ready = pr; dig_out_en = dg; amp_pdn = ap;
        #1;
        v = exp_view();
        chk("R1 R3 R5 R6 R9 read", rd_data, (a == IDX) ? v : 16'h0000);
        chk("R10 pins", {ser_en, 11'd0, ser2_en, sclk_en, fmt}, v);
        hit = we && (a == IDX);
        mn  = pr && (hit ? d[15] : m_q);
        s2_q = mn && (hit ? (d[3] && !dg) : s2_q);
        sc_q = mn && (hit ? (d[2] && !ap) : sc_q);
        if (hit) f_q = d[1:0];
        m_q = mn;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        m_q = 0; s2_q = 0; sc_q = 0; f_q = 0;
        repeat (3) @(negedge clk);
        #1;
        chk("R2 reset read", rd_data, 16'h0000);
        chk("R2 reset pins", {ser_en, 11'd0, ser2_en, sclk_en, fmt}, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: master refused without power
        step(1, IDX, 16'h800C, 0, 0, 0);
        step(0, IDX, 16'h0000, 1, 0, 0);
        chk("R3 refused set", rd_data, 16'h0000);
        // R8: joint write
        step(1, IDX, 16'h800E, 1, 0, 0);
        step(0, IDX, 16'h0000, 1, 0, 0);
        chk("R8 joint set", rd_data, 16'h800E);
        // R5/R6 gating of stored bits
        step(0, IDX, 16'h0000, 1, 1, 1);
        // R4: power loss then return
        step(0, IDX, 16'h0000, 0, 0, 0);
        step(0, IDX, 16'h0000, 1, 0, 0);
        chk("R4 stays off", rd_data, 16'h0002);
        // R7: cascade clear then re-arm
        step(1, IDX, 16'h800F, 1, 0, 0);
        step(1, IDX, 16'h0003, 1, 0, 0);
        step(1, IDX, 16'h8003, 1, 0, 0);
        step(0, IDX, 16'h0000, 1, 0, 0);
        chk("R7 deps cleared", rd_data, 16'h8003);
        // R5/R6: write refused under inhibit
        step(1, IDX, 16'h800C, 1, 1, 1);
        step(0, IDX, 16'h0000, 1, 0, 0);
        chk("R5 R6 refused", rd_data, 16'h8000);
        // R1: write elsewhere ignored
        step(1, 7'h5E, 16'h0001, 1, 0, 0);
        step(0, IDX, 16'h0000, 1, 0, 0);
        chk("R1 foreign write", rd_data, 16'h8000);
        // R9: reserved bits dropped
        step(1, IDX, 16'h7FF1, 1, 0, 0);
        step(0, IDX, 16'h0000, 1, 0, 0);
        chk("R9 reserved", rd_data, 16'h0001);

        // constrained random
        for (int i = 0; i < 3000; i++) begin
            bit we, pr, dg, ap;
            logic [6:0] a;
            logic [15:0] d;
            we = ($urandom_range(0, 2) != 0);
            a  = ($urandom_range(0, 7) == 0) ? 7'($urandom) : IDX;
            d  = 16'($urandom);
            if ($urandom_range(0, 1)) d[15] = 1'b1;
            pr = ($urandom_range(0, 9) != 0);
            dg = ($urandom_range(0, 3) == 0);
            ap = ($urandom_range(0, 3) == 0);
            step(we, a, d, pr, dg, ap);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule